// File: doc/BRIEF.md
# Nonvolatile Write Protection Controller

This block decides, one request at a time, whether a decoded register write may reach a nonvolatile target. It sits behind the byte-level decoder of a 2-wire register port. The targets are a 256-byte memory array held outside the block, three wiper position registers held inside it, and a control/status register, also inside. A 3-bit select code picks the target. Memory writes that are granted leave the block as a one-cycle write pulse with address and data. Wiper and control writes update the internal registers directly.

Protection comes from two places. The first is a 2-bit lock code in the control register: it fences off a top part of the memory array and freezes all three wipers. The second is an external write-protect pin, which blocks every write while it is high, including writes to the lock code itself. While the pin is low, the lock code stays writable, so a locked part can be unlocked again. A write that is refused produces a single reject pulse and changes nothing.

The three wipers have 256, 100 and 64 taps. A value larger than a wiper's top tap is stored as the top tap. The status byte combines the lock code and the delay-select field with the live states of two auxiliary monitor inputs.

Top module: `blocklock_guard`

## Requirements
- R1: Select code 3'b000 addresses the memory. A granted write raises `mem_we` for exactly one cycle, in the cycle after the strobe, with `mem_waddr`/`mem_wdata` equal to the request's address and data.
- R2: The lock code marks a protected memory region. Code 0 protects nothing, code 1 protects addresses 192..255, code 2 protects 128..255 and code 3 protects all addresses. A memory write into a protected address is rejected.
- R3: While `wprot` is 1, every write is rejected: memory, any wiper and the control register.
- R4: While the lock code is nonzero, every wiper write is rejected and the wiper values hold.
- R5: Select codes 3'b001, 3'b010 and 3'b011 address wipers 0, 1 and 2, which have 256, 100 and 64 taps. A granted write stores the value and pulses the matching bit 0, 1 or 2 of `wiper_we`. At most one bit of `wiper_we` is set at a time.
- R6: A wiper write value above the top tap (255, 99, 63) is stored as that top tap.
- R7: Select code 3'b100 addresses the control register. A granted write loads write-data bits [1:0] into the lock code and bits [3:2] into the delay select, and pulses `ctrl_we`.
- R8: With `wprot` at 0, the control register accepts writes whatever the lock code holds, so the lock can be cleared.
- R9: Select codes 3'b101 to 3'b111 are unmapped, and writes to them are rejected.
- R10: `status` is {2'b00, mon3, mon2, delay select[1:0], lock code[1:0]}, with bit 0 as the least significant bit.
- R11: A rejected write raises `reject` for exactly one cycle, in the cycle after the strobe. No write pulse is raised alongside it, and no stored value changes.
- R12: Reset clears the lock code, the delay select and all wipers to 0, and holds every pulse output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_wr | input | 1 | Write strobe, one cycle per request |
| acc_sel | input | 3 | Target select code |
| acc_addr | input | 8 | Memory byte address |
| acc_wdata | input | 8 | Write data |
| wprot | input | 1 | External write-protect, active high |
| mon2 | input | 1 | Auxiliary monitor output 2 state |
| mon3 | input | 1 | Auxiliary monitor output 3 state |
| mem_we | output | 1 | Granted memory write pulse |
| mem_waddr | output | 8 | Address of granted memory write |
| mem_wdata | output | 8 | Data of granted memory write |
| wiper_we | output | 3 | Granted wiper write pulses, one bit per wiper |
| ctrl_we | output | 1 | Granted control write pulse |
| reject | output | 1 | Refused write pulse |
| wiper0 | output | 8 | Wiper 0 position (256 taps) |
| wiper1 | output | 7 | Wiper 1 position (100 taps) |
| wiper2 | output | 6 | Wiper 2 position (64 taps) |
| lock_code | output | 2 | Current lock code |
| delay_sel | output | 2 | Current delay select field |
| status | output | 8 | Status byte for reads |

## Verification
The assertions assume that `acc_wr` is a single-cycle strobe, and that select, address, data and `wprot` are steady around the sampling edge. The rules "no pulse when idle" and "state holds after a refusal" only make sense under that assumption. The bench changes every input at the falling edge and returns `acc_wr` to 0 after one cycle. It never leaves the strobe high across two edges, and it changes `wprot` only between requests.

// File: rtl/blocklock_pkg.sv
package blocklock_pkg;

  localparam logic [2:0] SEL_MEM  = 3'd0;
  localparam logic [2:0] SEL_WIP0 = 3'd1;
  localparam logic [2:0] SEL_WIP1 = 3'd2;
  localparam logic [2:0] SEL_WIP2 = 3'd3;
  localparam logic [2:0] SEL_CTRL = 3'd4;

  localparam int NWIPER = 3;

  // top tap index reached by a wiper with the given number of positions
  function automatic int top_tap(int taps);
    return taps - 1;
  endfunction

  // requested value limited to the last valid tap
  function automatic int clamp_tap(int value, int taps);
    return (value > top_tap(taps)) ? top_tap(taps) : value;
  endfunction

  // lock code -> is this byte address inside the protected region
  function automatic logic region_locked(logic [1:0] code, int addr, int bytes);
    case (code)
      2'd0:    return 1'b0;
      2'd1:    return addr >= (bytes - bytes / 4);
      2'd2:    return addr >= (bytes / 2);
      default: return 1'b1;
    endcase
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/blocklock_region.sv
module blocklock_region
  import blocklock_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic [1:0]    lock_code,
  input  logic [AW-1:0] addr,
  output logic          hit
);

  always_comb hit = region_locked(lock_code, int'(addr), MEM_BYTES);

endmodule

// File: rtl/blocklock_wipers.sv
module blocklock_wipers
  import blocklock_pkg::*;
#(
  parameter int TAPS0 = 256,
  parameter int TAPS1 = 100,
  parameter int TAPS2 = 64,
  parameter int DW    = 8,
  localparam int WMAX = $clog2(max3(TAPS0, TAPS1, TAPS2))
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NWIPER-1:0]          we,
  input  logic [DW-1:0]              wdata,
  output logic [NWIPER-1:0][WMAX-1:0] pos
);

  for (genvar i = 0; i < NWIPER; i++) begin : g_wiper
    localparam int TAPS = (i == 0) ? TAPS0 : (i == 1) ? TAPS1 : TAPS2;
    logic [WMAX-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pos_q <= '0;
      else if (we[i]) pos_q <= WMAX'(clamp_tap(int'(wdata), TAPS));
    end

    assign pos[i] = pos_q;
  end

endmodule

// File: rtl/blocklock_ctrl.sv
module blocklock_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [3:0] wdata,
  input  logic       mon2,
  input  logic       mon3,
  output logic [1:0] lock_code,
  output logic [1:0] delay_sel,
  output logic [7:0] status
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_code <= 2'd0;
      delay_sel <= 2'd0;
    end else if (we) begin
      lock_code <= wdata[1:0];
      delay_sel <= wdata[3:2];
    end
  end

  assign status = {2'b00, mon3, mon2, delay_sel, lock_code};

endmodule

// File: rtl/blocklock_guard.sv
module blocklock_guard
  import blocklock_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int TAPS0     = 256,
  parameter int TAPS1     = 100,
  parameter int TAPS2     = 64,
  localparam int AW   = $clog2(MEM_BYTES),
  localparam int DW   = 8,
  localparam int W0   = $clog2(TAPS0),
  localparam int W1   = $clog2(TAPS1),
  localparam int W2   = $clog2(TAPS2),
  localparam int WMAX = $clog2(max3(TAPS0, TAPS1, TAPS2))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr,
  input  logic [2:0]        acc_sel,
  input  logic [AW-1:0]     acc_addr,
  input  logic [DW-1:0]     acc_wdata,
  input  logic              wprot,
  input  logic              mon2,
  input  logic              mon3,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [DW-1:0]     mem_wdata,
  output logic [NWIPER-1:0] wiper_we,
  output logic              ctrl_we,
  output logic              reject,
  output logic [W0-1:0]     wiper0,
  output logic [W1-1:0]     wiper1,
  output logic [W2-1:0]     wiper2,
  output logic [1:0]        lock_code,
  output logic [1:0]        delay_sel,
  output logic [7:0]        status
);

  // named decision events (also observed by the checker)
  logic              mem_hit;
  logic              grant_mem;
  logic [NWIPER-1:0] grant_wip;
  logic              grant_ctrl;
  logic              deny;
  logic [NWIPER-1:0][WMAX-1:0] wip_pos;

  blocklock_region #(.MEM_BYTES(MEM_BYTES)) u_region (
    .lock_code (lock_code),
    .addr      (acc_addr),
    .hit       (mem_hit)
  );

  always_comb begin
    grant_mem  = 1'b0;
    grant_wip  = '0;
    grant_ctrl = 1'b0;
    deny       = 1'b0;
    if (acc_wr) begin
      case (acc_sel)
        SEL_MEM: begin
          if (wprot || mem_hit) deny = 1'b1;
          else                  grant_mem = 1'b1;
        end
        SEL_WIP0, SEL_WIP1, SEL_WIP2: begin
          if (wprot || (lock_code != 2'd0)) deny = 1'b1;
          else grant_wip = NWIPER'(1) << (acc_sel - SEL_WIP0);
        end
        SEL_CTRL: begin
          if (wprot) deny = 1'b1;
          else       grant_ctrl = 1'b1;
        end
        default: deny = 1'b1;
      endcase
    end
  end

  blocklock_wipers #(
    .TAPS0 (TAPS0),
    .TAPS1 (TAPS1),
    .TAPS2 (TAPS2),
    .DW    (DW)
  ) u_wipers (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (grant_wip),
    .wdata (acc_wdata),
    .pos   (wip_pos)
  );

  blocklock_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (grant_ctrl),
    .wdata     (acc_wdata[3:0]),
    .mon2      (mon2),
    .mon3      (mon3),
    .lock_code (lock_code),
    .delay_sel (delay_sel),
    .status    (status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      wiper_we  <= '0;
      ctrl_we   <= 1'b0;
      reject    <= 1'b0;
    end else begin
      mem_we   <= grant_mem;
      wiper_we <= grant_wip;
      ctrl_we  <= grant_ctrl;
      reject   <= deny;
      if (grant_mem) begin
        mem_waddr <= acc_addr;
        mem_wdata <= acc_wdata;
      end
    end
  end

  assign wiper0 = wip_pos[0][W0-1:0];
  assign wiper1 = wip_pos[1][W1-1:0];
  assign wiper2 = wip_pos[2][W2-1:0];

endmodule

// File: rtl/blocklock_guard_chk.sv
module blocklock_guard_chk #(
  parameter int TAPS1 = 100,
  parameter int TAPS2 = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_wr,
  input logic [2:0] acc_sel,
  input logic       wprot,
  input logic       mem_hit,
  input logic       mem_we,
  input logic [2:0] wiper_we,
  input logic       ctrl_we,
  input logic       reject,
  input logic [7:0] wiper0,
  input logic [6:0] wiper1,
  input logic [5:0] wiper2,
  input logic [1:0] lock_code,
  input logic [1:0] delay_sel
);

  a_r3_wprot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && wprot |=> reject && !mem_we && (wiper_we == 3'b000) && !ctrl_we);

  a_r2_region_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && (acc_sel == 3'd0) && mem_hit |=> reject && !mem_we);

  a_r4_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && (acc_sel >= 3'd1) && (acc_sel <= 3'd3) && (lock_code != 2'd0)
    |=> (wiper_we == 3'b000) && $stable(wiper0) && $stable(wiper1) && $stable(wiper2));

  a_r6_tap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wiper1) <= TAPS1 - 1) && (int'(wiper2) <= TAPS2 - 1));

  a_r5_one_wiper: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wiper_we));

  a_r9_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && (acc_sel > 3'd4) |=> reject);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !mem_we && (wiper_we == 3'b000) && !ctrl_we);

  a_r11_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> $stable(lock_code) && $stable(delay_sel) && $stable(wiper0)
               && $stable(wiper1) && $stable(wiper2));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> !reject && !mem_we && !ctrl_we && (wiper_we == 3'b000));

endmodule

bind blocklock_guard blocklock_guard_chk #(.TAPS1(TAPS1), .TAPS2(TAPS2)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_wr    (acc_wr),
  .acc_sel   (acc_sel),
  .wprot     (wprot),
  .mem_hit   (mem_hit),
  .mem_we    (mem_we),
  .wiper_we  (wiper_we),
  .ctrl_we   (ctrl_we),
  .reject    (reject),
  .wiper0    (wiper0),
  .wiper1    (wiper1),
  .wiper2    (wiper2),
  .lock_code (lock_code),
  .delay_sel (delay_sel)
);

// File: tb/blocklock_guard_tb.sv
module blocklock_guard_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_wr = 1'b0;
  logic [2:0] acc_sel = 3'd0;
  logic [7:0] acc_addr = 8'd0;
  logic [7:0] acc_wdata = 8'd0;
  logic       wprot = 1'b0;
  logic       mon2 = 1'b0;
  logic       mon3 = 1'b0;
  logic       mem_we, ctrl_we, reject;
  logic [7:0] mem_waddr, mem_wdata, status, wiper0;
  logic [2:0] wiper_we;
  logic [6:0] wiper1;
  logic [5:0] wiper2;
  logic [1:0] lock_code, delay_sel;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  blocklock_guard u_dut (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_sel(acc_sel),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .wprot(wprot),
    .mon2(mon2), .mon3(mon3), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .wiper_we(wiper_we), .ctrl_we(ctrl_we),
    .reject(reject), .wiper0(wiper0), .wiper1(wiper1), .wiper2(wiper2),
    .lock_code(lock_code), .delay_sel(delay_sel), .status(status)
  );

  typedef struct packed {
    logic [2:0] sel;
    logic [7:0] addr;
    logic [7:0] data;
    logic       wp;
    logic       rej;
    logic       mem;
    logic [2:0] wip;
    logic       ctl;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 8'h10, 8'hAA, 1'b0, 1'b0, 1'b1, 3'b000, 1'b0, 4'd1},  // R1 open memory write
    '{3'd1, 8'h00, 8'h80, 1'b0, 1'b0, 1'b0, 3'b001, 1'b0, 4'd5},  // R5 wiper 0
    '{3'd2, 8'h00, 8'd200,1'b0, 1'b0, 1'b0, 3'b010, 1'b0, 4'd6},  // R6 clamp to 99
    '{3'd3, 8'h00, 8'h3F, 1'b0, 1'b0, 1'b0, 3'b100, 1'b0, 4'd5},  // R5 top tap exact
    '{3'd3, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0, 3'b100, 1'b0, 4'd6},  // R6 clamp to 63
    '{3'd4, 8'h00, 8'h01, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1, 4'd7},  // R7 lock upper quarter
    '{3'd0, 8'hC0, 8'h11, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 4'd2},  // R2 first protected byte
    '{3'd0, 8'hBF, 8'h22, 1'b0, 1'b0, 1'b1, 3'b000, 1'b0, 4'd2},  // R2 last open byte
    '{3'd1, 8'h00, 8'h05, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 4'd4},  // R4 wiper frozen
    '{3'd4, 8'h00, 8'h02, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1, 4'd8},  // R8 relock while locked
    '{3'd0, 8'h80, 8'h33, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 4'd2},  // R2 upper half
    '{3'd0, 8'h7F, 8'h44, 1'b0, 1'b0, 1'b1, 3'b000, 1'b0, 4'd2},  // R2 lower half open
    '{3'd4, 8'h00, 8'h0F, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1, 4'd7},  // R7 lock all, delay 3
    '{3'd0, 8'h00, 8'h55, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 4'd2},  // R2 whole array
    '{3'd2, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 4'd4},  // R4 wiper 1 frozen
    '{3'd4, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0, 4'd3},  // R3 pin blocks control
    '{3'd4, 8'h00, 8'h04, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1, 4'd8},  // R8 clear lock, delay 1
    '{3'd0, 8'hFF, 8'h66, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0, 4'd3},  // R3 pin blocks memory
    '{3'd1, 8'h00, 8'h11, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0, 4'd3},  // R3 pin blocks wiper
    '{3'd5, 8'h00, 8'h77, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 4'd9},  // R9 unmapped code
    '{3'd2, 8'h00, 8'd50, 1'b0, 1'b0, 1'b0, 3'b010, 1'b0, 4'd5}   // R5 wiper 1 unlocked
  };

  // bench model of stored state, built from the requirements
  int m_w0 = 0, m_w1 = 0, m_w2 = 0, m_lock = 0, m_dly = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    chk({tag, " wiper0"}, int'(wiper0), m_w0);
    chk({tag, " wiper1"}, int'(wiper1), m_w1);
    chk({tag, " wiper2"}, int'(wiper2), m_w2);
    chk({tag, " lock"}, int'(lock_code), m_lock);
    chk({tag, " delay"}, int'(delay_sel), m_dly);
  endtask

  function automatic int limit(int v, int lim);
    if (v <= lim) return v;
    return lim;
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 mem_we in reset", int'(mem_we), 0);
    chk("R12 reject in reset", int'(reject), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R12 after reset");
    chk("R12 wiper_we", int'(wiper_we), 0);
    chk("R12 ctrl_we", int'(ctrl_we), 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      acc_sel = VEC[i].sel;
      acc_addr = VEC[i].addr;
      acc_wdata = VEC[i].data;
      wprot = VEC[i].wp;
      acc_wr = 1'b1;
      @(negedge clk);
      acc_wr = 1'b0;
      chk({tag, " reject"}, int'(reject), int'(VEC[i].rej));
      chk({tag, " mem_we"}, int'(mem_we), int'(VEC[i].mem));
      chk({tag, " wiper_we"}, int'(wiper_we), int'(VEC[i].wip));
      chk({tag, " ctrl_we"}, int'(ctrl_we), int'(VEC[i].ctl));
      if (VEC[i].mem) begin
        chk({tag, " R1 addr"}, int'(mem_waddr), int'(VEC[i].addr));
        chk({tag, " R1 data"}, int'(mem_wdata), int'(VEC[i].data));
      end
      if (VEC[i].wip[0]) m_w0 = limit(int'(VEC[i].data), 255);
      if (VEC[i].wip[1]) m_w1 = limit(int'(VEC[i].data), 99);
      if (VEC[i].wip[2]) m_w2 = limit(int'(VEC[i].data), 63);
      if (VEC[i].ctl) begin
        m_lock = int'(VEC[i].data) % 4;
        m_dly = (int'(VEC[i].data) / 4) % 4;
      end
      check_state(tag);
      if (VEC[i].rej) begin
        // R11 pulse lasts a single cycle
        @(negedge clk);
        chk({tag, " R11 reject drops"}, int'(reject), 0);
      end
      wprot = 1'b0;
    end

    // R10 status byte with monitor states
    mon2 = 1'b1; mon3 = 1'b0;
    #1;
    chk("R10 status mon2", int'(status), 16 + m_dly * 4 + m_lock);
    mon2 = 1'b0; mon3 = 1'b1;
    #1;
    chk("R10 status mon3", int'(status), 32 + m_dly * 4 + m_lock);

    // R12 mid-run reset returns everything to zero
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    m_w0 = 0; m_w1 = 0; m_w2 = 0; m_lock = 0; m_dly = 0;
    check_state("R12 second reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule